// File: doc/BRIEF.md
# Thermostat Alert Engine with Consecutive-Fault Filter

This block sits beside a temperature converter and turns its stream of 12-bit results into an over-temperature alert. Each time the converter signals that a result is ready, the result is compared, as a signed two's complement number, with a programmable upper limit and a programmable lower limit. A fault filter demands a selectable number of consecutive qualifying results before the thermostat state changes, so single noisy samples do not toggle the alert.

The thermostat state is a hysteresis flag: it becomes active after enough results at or above the upper limit and goes inactive after enough results strictly below the lower limit. In level mode the alert pin simply shows that flag. In event mode every change of the flag latches an event, which alternates between an upper-limit event and a lower-limit event and stays latched until a register read, a successful alert-response transaction, or entry into shutdown clears it. A polarity input selects whether the alert pin and the status readback bit are active low or active high. The register file and the bus logic that drive the control inputs are outside this block.

Top module: `thermo_alert_unit`

## Requirements
- R1: An upper fault is a result with signed value greater than or equal to `lim_hi`; a lower fault is a result with signed value strictly less than `lim_lo`. All 12 bits of the result and of both limits take part, so a one-LSB difference decides the outcome, and 0x800 (the most negative code) is below 0x7F0.
- R2: `fq_sel` codes 2'b00, 2'b01, 2'b10, 2'b11 require 1, 2, 4 and 6 consecutive qualifying results. A result that does not meet the pending condition restarts the count; cycles without `conv_done` leave the count unchanged.
- R3: The thermostat state goes from inactive to active after the required run of upper faults, and from active to inactive after the required run of lower faults; while active, upper faults are not counted, and while inactive, lower faults are not counted. It changes in the cycle after the `conv_done` cycle that completes the run, and at no other time.
- R4: `os_bit` shows the thermostat state in either mode: with `pol_hi`=0 it is 1 while inactive and 0 while active; `pol_hi`=1 inverts it.
- R5: With `intr_mode`=0, `alert_out` shows the thermostat state: `pol_hi`=0 gives active low (0 while active), `pol_hi`=1 gives active high.
- R6: With `intr_mode`=1, every change of the thermostat state latches an event, and `alert_out` shows the latched event with the same polarity rule as R5; the event stays latched until cleared.
- R7: A latched event is cleared in the cycle after any of: `reg_read`, `ar_done`, or a 0-to-1 change of `shutdown`. An event raised in the same cycle as a clear request wins.
- R8: After an upper event is cleared, further upper faults raise nothing; only a run of lower faults raises the next event, after which only upper faults can.
- R9: `resp_status` is the cause of the latched event: 0 for an upper event and 1 for a lower event when `pol_hi`=0, inverted when `pol_hi`=1. The cause is captured when an event is raised while none is latched and is held until the next such event; it resets to the upper code.
- R10: `gc_reset` returns the thermostat state, the fault count, the latched event and the cause to their reset values in the next cycle, and with `intr_mode`=0 no event stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle pulse: a new result is on `temp_in` |
| temp_in | input | 12 | Signed conversion result |
| lim_hi | input | 12 | Signed upper limit |
| lim_lo | input | 12 | Signed lower limit |
| fq_sel | input | 2 | Consecutive-fault count select |
| intr_mode | input | 1 | 0 level mode, 1 event mode |
| pol_hi | input | 1 | 0 active-low outputs, 1 active-high |
| reg_read | input | 1 | Pulse: some register was read |
| ar_done | input | 1 | Pulse: alert-response transaction won |
| shutdown | input | 1 | Shutdown level from the mode register |
| gc_reset | input | 1 | Pulse: bus-wide reset command |
| alert_out | output | 1 | Alert line |
| os_bit | output | 1 | Thermostat status readback bit |
| resp_status | output | 1 | Cause bit for the alert response |

## Verification
The bench attacks the comparison edges: a result equal to the upper limit (a design using a strict compare would miss it), a result equal to the lower limit (an inclusive compare would release too early), one-LSB limit offsets, and the signed wrap where 0x800 must not trip a limit near +127. It runs the six-deep filter with a break at the fifth fault and with idle cycles inside the run, which catches a counter that does not restart or that counts clocks instead of results. In event mode it clears by read, alert response and shutdown entry, checks that a repeated upper run raises nothing after a clear, and checks that the cause bit stays frozen while an event is latched; a random phase then mixes all strobes, limits, modes and polarities against a bench model.

// File: rtl/thermo_alert_pkg.sv
package thermo_alert_pkg;

    // Cause code carried in the alert-response status bit (before polarity).
    typedef enum logic {
        CAUSE_UPPER = 1'b0,
        CAUSE_LOWER = 1'b1
    } cause_e;

    // Fault-count select codes.
    typedef enum logic [1:0] {
        FQ_SEL_A = 2'b00,
        FQ_SEL_B = 2'b01,
        FQ_SEL_C = 2'b10,
        FQ_SEL_D = 2'b11
    } fq_code_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ta_limit_cmp.sv
module ta_limit_cmp #(
    parameter int unsigned TEMP_W = 12
) (
    input  logic [TEMP_W-1:0] temp_in,
    input  logic [TEMP_W-1:0] lim_hi,
    input  logic [TEMP_W-1:0] lim_lo,
    output logic              hi_fault,
    output logic              lo_fault
);

    logic signed [TEMP_W-1:0] t_s;
    logic signed [TEMP_W-1:0] h_s;
    logic signed [TEMP_W-1:0] l_s;

    always_comb begin
        t_s      = $signed(temp_in);
        h_s      = $signed(lim_hi);
        l_s      = $signed(lim_lo);
        hi_fault = (t_s >= h_s);
        lo_fault = (t_s < l_s);
    end

endmodule

// File: rtl/ta_fault_queue.sv
module ta_fault_queue
    import thermo_alert_pkg::*;
#(
    parameter int unsigned DEPTH_A = 1,
    parameter int unsigned DEPTH_B = 2,
    parameter int unsigned DEPTH_C = 4,
    parameter int unsigned DEPTH_D = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gc_reset,
    input  logic       conv_done,
    input  logic       hi_fault,
    input  logic       lo_fault,
    input  logic [1:0] fq_sel,
    output logic       act,
    output logic       flip
);

    localparam int unsigned DEPTH_MAX = max4(DEPTH_A, DEPTH_B, DEPTH_C, DEPTH_D);
    localparam int unsigned CNT_W     = $clog2(DEPTH_MAX + 1);

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
    } fq_state_t;

    fq_state_t        st_d, st_q;
    logic [CNT_W:0]   need_d;
    logic [CNT_W:0]   next_cnt_d;
    logic             pend_d;
    logic             flip_d;

    always_comb begin
        unique case (fq_code_e'(fq_sel))
            FQ_SEL_A: need_d = (CNT_W+1)'(DEPTH_A);
            FQ_SEL_B: need_d = (CNT_W+1)'(DEPTH_B);
            FQ_SEL_C: need_d = (CNT_W+1)'(DEPTH_C);
            default:  need_d = (CNT_W+1)'(DEPTH_D);
        endcase

        st_d       = st_q;
        flip_d     = 1'b0;
        pend_d     = st_q.act ? lo_fault : hi_fault;
        next_cnt_d = {1'b0, st_q.cnt} + 1'b1;

        if (gc_reset) begin
            st_d = '0;
        end else if (conv_done) begin
            if (!pend_d) begin
                st_d.cnt = '0;
            end else if (next_cnt_d >= need_d) begin
                st_d.act = ~st_q.act;
                st_d.cnt = '0;
                flip_d   = 1'b1;
            end else begin
                st_d.cnt = next_cnt_d[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act  = st_q.act;
    assign flip = flip_d;

endmodule

// File: rtl/ta_event_latch.sv
module ta_event_latch
    import thermo_alert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gc_reset,
    input  logic intr_mode,
    input  logic flip,
    input  logic act,
    input  logic reg_read,
    input  logic ar_done,
    input  logic shutdown,
    output logic flag,
    output logic cause
);

    typedef struct packed {
        logic   flag;
        cause_e cause;
        logic   sd_prev;
    } ev_state_t;

    ev_state_t st_d, st_q;
    logic      clr_d;

    always_comb begin
        st_d         = st_q;
        st_d.sd_prev = shutdown;
        clr_d        = reg_read | ar_done | (shutdown & ~st_q.sd_prev);

        if (gc_reset) begin
            st_d.flag  = 1'b0;
            st_d.cause = CAUSE_UPPER;
        end else if (!intr_mode) begin
            st_d.flag = 1'b0;
        end else if (flip) begin
            // act is the state before the change: leaving active means lower cause
            if (!st_q.flag) begin
                st_d.cause = act ? CAUSE_LOWER : CAUSE_UPPER;
            end
            st_d.flag = 1'b1;
        end else if (clr_d) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flag: 1'b0, cause: CAUSE_UPPER, sd_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag  = st_q.flag;
    assign cause = st_q.cause;

endmodule

// File: rtl/thermo_alert_unit.sv
module thermo_alert_unit #(
    parameter int unsigned TEMP_W  = 12,
    parameter int unsigned DEPTH_A = 1,
    parameter int unsigned DEPTH_B = 2,
    parameter int unsigned DEPTH_C = 4,
    parameter int unsigned DEPTH_D = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [TEMP_W-1:0] temp_in,
    input  logic [TEMP_W-1:0] lim_hi,
    input  logic [TEMP_W-1:0] lim_lo,
    input  logic [1:0]        fq_sel,
    input  logic              intr_mode,
    input  logic              pol_hi,
    input  logic              reg_read,
    input  logic              ar_done,
    input  logic              shutdown,
    input  logic              gc_reset,
    output logic              alert_out,
    output logic              os_bit,
    output logic              resp_status
);

    logic hi_fault_w;
    logic lo_fault_w;
    logic act_w;
    logic flip_w;
    logic flag_w;
    logic cause_w;
    logic shown_w;

    ta_limit_cmp #(
        .TEMP_W (TEMP_W)
    ) cmp_i (
        .temp_in  (temp_in),
        .lim_hi   (lim_hi),
        .lim_lo   (lim_lo),
        .hi_fault (hi_fault_w),
        .lo_fault (lo_fault_w)
    );

    ta_fault_queue #(
        .DEPTH_A (DEPTH_A),
        .DEPTH_B (DEPTH_B),
        .DEPTH_C (DEPTH_C),
        .DEPTH_D (DEPTH_D)
    ) fq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .gc_reset  (gc_reset),
        .conv_done (conv_done),
        .hi_fault  (hi_fault_w),
        .lo_fault  (lo_fault_w),
        .fq_sel    (fq_sel),
        .act       (act_w),
        .flip      (flip_w)
    );

    ta_event_latch ev_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .gc_reset  (gc_reset),
        .intr_mode (intr_mode),
        .flip      (flip_w),
        .act       (act_w),
        .reg_read  (reg_read),
        .ar_done   (ar_done),
        .shutdown  (shutdown),
        .flag      (flag_w),
        .cause     (cause_w)
    );

    always_comb begin
        shown_w     = intr_mode ? flag_w : act_w;
        alert_out   = pol_hi ? shown_w : ~shown_w;
        os_bit      = pol_hi ? act_w : ~act_w;
        resp_status = cause_w ^ pol_hi;
    end

endmodule

// File: rtl/thermo_alert_chk.sv
module thermo_alert_chk #(
    parameter int unsigned TEMP_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [TEMP_W-1:0] temp_in,
    input logic [TEMP_W-1:0] lim_hi,
    input logic [1:0]        fq_sel,
    input logic              intr_mode,
    input logic              reg_read,
    input logic              gc_reset,
    input logic              alert_out,
    input logic              os_bit,
    input logic              act_q,
    input logic              flag_q
);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_done && !gc_reset) |=> $stable(act_q));

    p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !gc_reset && fq_sel == 2'b00 && !act_q &&
         ($signed(temp_in) >= $signed(lim_hi))) |=> act_q);

    p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !intr_mode |-> (alert_out == os_bit));

    p_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(conv_done) && $past(intr_mode)));

    p_rdclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_read && !conv_done) |=> !flag_q);

    p_gc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gc_reset |=> (!act_q && !flag_q));

    p_nolatch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !intr_mode |=> !flag_q);

endmodule

bind thermo_alert_unit thermo_alert_chk #(.TEMP_W(TEMP_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .temp_in   (temp_in),
    .lim_hi    (lim_hi),
    .fq_sel    (fq_sel),
    .intr_mode (intr_mode),
    .reg_read  (reg_read),
    .gc_reset  (gc_reset),
    .alert_out (alert_out),
    .os_bit    (os_bit),
    .act_q     (act_w),
    .flag_q    (flag_w)
);

// File: tb/thermo_alert_unit_tb_top.sv
`timescale 1ns/1ps
module thermo_alert_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] temp_in = '0;
    logic [11:0] lim_hi = 12'h500;
    logic [11:0] lim_lo = 12'h4B0;
    logic [1:0]  fq_sel = 2'b00;
    logic        intr_mode = 1'b0;
    logic        pol_hi = 1'b0;
    logic        reg_read = 1'b0;
    logic        ar_done = 1'b0;
    logic        shutdown = 1'b0;
    logic        gc_reset = 1'b0;
    logic        alert_out, os_bit, resp_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model state
    bit       m_act = 0;
    int       m_cnt = 0;
    bit       m_flag = 0;
    bit       m_cause = 0;
    bit       m_sd = 0;

    always #2 clk = ~clk;

    thermo_alert_unit dut_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp_in(temp_in),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .fq_sel(fq_sel), .intr_mode(intr_mode),
        .pol_hi(pol_hi), .reg_read(reg_read), .ar_done(ar_done), .shutdown(shutdown),
        .gc_reset(gc_reset), .alert_out(alert_out), .os_bit(os_bit),
        .resp_status(resp_status)
    );

    function automatic int need_of(input logic [1:0] c);
        case (c)
            2'b00: return 1;
            2'b01: return 2;
            2'b10: return 4;
            default: return 6;
        endcase
    endfunction

    function automatic bit e_alert();
        bit sh;
        sh = intr_mode ? m_flag : m_act;
        return pol_hi ? sh : !sh;
    endfunction

    function automatic bit e_os();
        return pol_hi ? m_act : !m_act;
    endfunction

    function automatic bit e_status();
        return m_cause ^ pol_hi;
    endfunction

    task automatic chk(input string tag, input logic act_v, input logic exp_v);
        n_checks++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // One cycle of stimulus, model update, and a check of all outputs.
    task automatic step(input bit cd, input logic [11:0] t, input bit rd, input bit ar,
                        input bit sd, input bit gc, input string tag);
        bit pend, raise, clr;
        @(negedge clk);
        conv_done = cd; temp_in = t; reg_read = rd; ar_done = ar;
        shutdown = sd; gc_reset = gc;
        raise = 0;
        if (gc) begin
            m_act = 0; m_cnt = 0; m_flag = 0; m_cause = 0;
        end else begin
            if (cd) begin
                pend = m_act ? ($signed(t) < $signed(lim_lo)) : ($signed(t) >= $signed(lim_hi));
                if (!pend) m_cnt = 0;
                else if (m_cnt + 1 >= need_of(fq_sel)) begin
                    m_act = !m_act; m_cnt = 0; raise = 1;
                end else m_cnt++;
            end
            clr = rd | ar | (sd & !m_sd);
            if (!intr_mode) m_flag = 0;
            else if (raise) begin
                if (!m_flag) m_cause = m_act ? 1'b0 : 1'b1;
                m_flag = 1;
            end else if (clr) m_flag = 0;
        end
        m_sd = sd;
        @(posedge clk);
        #1;
        chk({tag, " alert (R5/R6)"}, alert_out, e_alert());
        chk({tag, " os (R4)"}, os_bit, e_os());
        chk({tag, " status (R9)"}, resp_status, e_status());
    endtask

    task automatic conv(input logic [11:0] t, input string tag);
        step(1, t, 0, 0, shutdown, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, temp_in, 0, 0, shutdown, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state, pol=0
        chk("R4 reset os", os_bit, 1'b1);
        chk("R5 reset alert", alert_out, 1'b1);
        chk("R9 reset status", resp_status, 1'b0);

        // R1: limit edges, single-result filter
        conv(12'h4FF, "R1 below hi");
        chk("R1 one LSB under upper limit", os_bit, 1'b1);
        conv(12'h500, "R1 equal hi");
        chk("R1 equal to upper limit trips", os_bit, 1'b0);
        conv(12'h4B0, "R1 equal lo");
        chk("R1 equal to lower limit holds", os_bit, 1'b0);
        conv(12'h4AF, "R1 under lo");
        chk("R1 one LSB under lower limit releases", os_bit, 1'b1);
        lim_hi = 12'h7F0;
        conv(12'h800, "R1 signed");
        chk("R1 most negative code is not an upper fault", os_bit, 1'b1);
        lim_hi = 12'h500;

        // R2/R3: six-deep filter with a break and idle cycles
        fq_sel = 2'b11;
        for (int i = 0; i < 5; i++) conv(12'h600, "R2 run1");
        conv(12'h100, "R2 break");
        for (int i = 0; i < 5; i++) begin
            conv(12'h600, "R2 run2");
            idle("R2 idle");
        end
        chk("R2 five after break not enough", os_bit, 1'b1);
        conv(12'h600, "R2 sixth");
        chk("R3 sixth consecutive upper fault", os_bit, 1'b0);
        for (int i = 0; i < 5; i++) conv(12'h100, "R3 low run");
        chk("R3 five lower faults keep active", os_bit, 1'b0);
        conv(12'h100, "R3 low sixth");
        chk("R3 release after six lower faults", os_bit, 1'b1);

        // R4/R5 polarity
        pol_hi = 1'b1;
        idle("R4 pol");
        chk("R5 active-high idle alert", alert_out, 1'b0);
        chk("R4 inverted os", os_bit, 1'b0);
        pol_hi = 1'b0;

        // R6/R7/R8/R9 event mode
        fq_sel = 2'b00;
        intr_mode = 1'b1;
        conv(12'h600, "R6 up event");
        chk("R6 upper event raised", alert_out, 1'b0);
        chk("R9 upper cause", resp_status, 1'b0);
        step(0, 12'h600, 1, 0, 0, 0, "R7 read");
        chk("R7 read clears", alert_out, 1'b1);
        conv(12'h600, "R8 repeat up");
        chk("R8 upper again raises nothing", alert_out, 1'b1);
        conv(12'h100, "R8 low event");
        chk("R8 lower event raised", alert_out, 1'b0);
        chk("R9 lower cause", resp_status, 1'b1);
        step(0, 12'h100, 0, 1, 0, 0, "R7 ar");
        chk("R7 alert response clears", alert_out, 1'b1);
        conv(12'h600, "R6 up2");
        step(0, 12'h600, 0, 0, 1, 0, "R7 sd");
        chk("R7 shutdown entry clears", alert_out, 1'b1);
        conv(12'h100, "R9 low in sd");
        conv(12'h600, "R9 up while latched");
        chk("R9 cause frozen while latched", resp_status, 1'b1);
        step(1, 12'h600, 1, 0, 1, 0, "R7 raise wins");
        step(0, 12'h600, 0, 0, 0, 0, "R7 sd low");

        // R10
        step(0, 12'h600, 0, 0, 0, 1, "R10 gc");
        chk("R10 gc releases os", os_bit, 1'b1);
        chk("R10 gc clears event", alert_out, 1'b1);
        conv(12'h600, "R10 up");
        intr_mode = 1'b0;
        idle("R10 level mode");
        chk("R10 no latched event in level mode", alert_out, 1'b0);

        // random phase
        for (int blk = 0; blk < 12; blk++) begin
            lim_hi    = 12'($urandom_range(0, 2000)) - 12'd1000;
            lim_lo    = lim_hi - 12'($urandom_range(0, 40));
            fq_sel    = 2'($urandom_range(0, 3));
            intr_mode = 1'($urandom_range(0, 1));
            pol_hi    = 1'($urandom_range(0, 1));
            for (int i = 0; i < 250; i++) begin
                logic [11:0] base;
                bit sd_n;
                base = ($urandom_range(0, 1) != 0) ? lim_hi : lim_lo;
                sd_n = ($urandom_range(0, 39) == 0) ? !shutdown : shutdown;
                step(($urandom_range(0, 9) < 6),
                     base + 12'($urandom_range(0, 8)) - 12'd4,
                     ($urandom_range(0, 15) == 0),
                     ($urandom_range(0, 31) == 0),
                     sd_n,
                     ($urandom_range(0, 299) == 0),
                     "R3 random");
            end
        end
        report();
    end

endmodule